// File: doc/BRIEF.md
# Serial TDM Frame Timing Generator

This block derives all bus-side timing for a 2.048 Mb/s time-division multiplexed voice bus of 256 bit cells per 8 kHz frame. It runs from a single timing clock that ticks four times per bit cell, which is both edges of the 4.096 MHz master clock. It aligns a frame position counter to an active-low frame pulse. From that position it decodes a half-rate bit clock, a strobe marking the first voice channel, a delayed frame pulse, and one-tick shift and sample enables for the serial data pins.

The mode input chooses between 8-bit companded channels and a 16-bit linear channel. In linear mode the channel strobe narrows to a single bit cell and the delayed frame pulse is suppressed. When the frame pulse input stays high for two whole frames, the block treats the bus as absent and enters slave mode. In slave mode it drops its output-enable, which stands in for tri-stating the bit clock and strobe pins, and silences every timing output. The next frame pulse returns it to bus mode.

Top module: `tdm_frame_timer`

## Requirements
- R1: While reset is held, the position is bit 0, tick 0 in bus mode: oe_o=1, bus_mode_o=1, shift_tick_o=1, ch_en_o=1, bclk_o=0, sample_tick_o=0, dfp_o=0 (companded).
- R2: When fp_ni is low at a rising clk_i edge, the outputs after that edge show bit 0, tick 0 of a new frame, wherever the frame stood before.
- R3: bclk_o is low during ticks 0 and 1 of each bit cell and high during ticks 2 and 3, so it rises mid-cell.
- R4: shift_tick_o is high only on tick 0 of each cell, and sample_tick_o only on tick 3, the three-quarter point.
- R5: With lin_i=0, ch_en_o is high for all ticks of bit cells 0 to 7 and low elsewhere.
- R6: With lin_i=1, ch_en_o is high only during bit cell 0.
- R7: dfp_o is high during bit cell 16 when lin_i=0, and is never high when lin_i=1.
- R8: Without a frame pulse, the position wraps from bit 255, tick 3 to bit 0, tick 0.
- R9: After 2048 consecutive clk_i edges with fp_ni high, oe_o and bus_mode_o go low and bclk_o, ch_en_o, dfp_o, shift_tick_o and sample_tick_o are held low.
- R10: In slave mode, a low fp_ni at a clk_i edge restores bus mode with bit 0, tick 0 timing after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, four ticks per bit cell |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_ni | input | 1 | Frame pulse, active low, one tick wide |
| lin_i | input | 1 | 1 selects the 16-bit linear channel, 0 selects 8-bit companded |
| bclk_o | output | 1 | Inverted half-rate bit clock |
| oe_o | output | 1 | Output-enable for the bit clock and strobe pins |
| ch_en_o | output | 1 | First-channel enable strobe, active high |
| dfp_o | output | 1 | Delayed frame pulse, active high |
| shift_tick_o | output | 1 | One-tick enable to shift out data at cell start |
| sample_tick_o | output | 1 | One-tick enable to sample input data |
| bus_mode_o | output | 1 | 1 in bus mode, 0 in slave mode |

## Verification
A wrong position count shows first on shift_tick_o and bclk_o, which move within one tick. A count off by whole cells shows on ch_en_o or dfp_o within one frame, and at the latest at the next pulse, which forces the count to zero. A miss counter that trips early drops oe_o well before 2048 quiet ticks, and one that never trips leaves the strobes running past that mark. The bench therefore compares every output on every tick against a model that tracks the position and the quiet time from the pulse input alone.

// File: rtl/tdm_timer_pkg.sv
package tdm_timer_pkg;
  typedef struct packed {
    logic bclk;
    logic ch_en;
    logic dfp;
    logic shift;
    logic sample;
  } tdm_strb_t;
endpackage

// File: rtl/tdm_pos_cnt.sv
module tdm_pos_cnt #(
  parameter int TICKS_PER_BIT = 4,
  parameter int FRAME_BITS    = 256,
  parameter int CNT_W         = $clog2(TICKS_PER_BIT * FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  output logic [CNT_W-1:0] pos_o
);
  localparam int FRAME_TICKS = TICKS_PER_BIT * FRAME_BITS;
  localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(FRAME_TICKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pos_o <= '0;
    else if (!fp_ni)          pos_o <= '0;
    else if (pos_o == POS_LAST) pos_o <= '0;
    else                      pos_o <= pos_o + 1'b1;
  end

  p_realign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> pos_o == '0);
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_ni && pos_o == POS_LAST) |=> pos_o == '0);
endmodule

// File: rtl/tdm_sync_mon.sv
module tdm_sync_mon #(
  parameter int LIMIT  = 2048,
  parameter int MISS_W = $clog2(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fp_ni,
  output logic slave_o
);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LIMIT - 1);
  logic [MISS_W-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q  <= '0;
      slave_o <= 1'b0;
    end else if (!fp_ni) begin
      miss_q  <= '0;
      slave_o <= 1'b0;
    end else if (miss_q == MISS_LAST) begin
      slave_o <= 1'b1;
    end else begin
      miss_q <= miss_q + 1'b1;
    end
  end

  p_resume_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> !slave_o);
  p_slave_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_o && fp_ni) |=> slave_o);
endmodule

// File: rtl/tdm_strb_dec.sv
module tdm_strb_dec
  import tdm_timer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int FRAME_BITS    = 256,
  parameter int CH_BITS       = 8,
  parameter int DFP_BIT       = 16,
  parameter int CNT_W         = $clog2(TICKS_PER_BIT * FRAME_BITS)
) (
  input  logic [CNT_W-1:0] pos_i,
  input  logic             lin_i,
  input  logic             slave_i,
  output tdm_strb_t        strb_o
);
  localparam int SUB_W = $clog2(TICKS_PER_BIT);
  localparam int BIT_W = CNT_W - SUB_W;
  localparam logic [BIT_W-1:0] CH_END  = BIT_W'(CH_BITS);
  localparam logic [BIT_W-1:0] DFP_POS = BIT_W'(DFP_BIT);
  localparam logic [SUB_W-1:0] HALF    = SUB_W'(TICKS_PER_BIT / 2);

  logic [BIT_W-1:0] bit_idx;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] samp_pos;
  tdm_strb_t        raw;

  assign bit_idx = pos_i[CNT_W-1:SUB_W];
  assign sub     = pos_i[SUB_W-1:0];

  // sample point: three-quarter of the cell, or the last tick for short cells
  generate
    if (TICKS_PER_BIT >= 4) begin : g_qtr
      assign samp_pos = SUB_W'((3 * TICKS_PER_BIT) / 4);
    end else begin : g_last
      assign samp_pos = SUB_W'(TICKS_PER_BIT - 1);
    end
  endgenerate

  always_comb begin
    raw.bclk   = (sub >= HALF);
    raw.shift  = (sub == '0);
    raw.sample = (sub == samp_pos);
    raw.ch_en  = lin_i ? (bit_idx == '0) : (bit_idx < CH_END);
    raw.dfp    = !lin_i && (bit_idx == DFP_POS);
    strb_o     = slave_i ? '0 : raw;
  end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_timer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int FRAME_BITS    = 256,
  parameter int CH_BITS       = 8,
  parameter int DFP_BIT       = 16,
  parameter int MISS_FRAMES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fp_ni,
  input  logic lin_i,
  output logic bclk_o,
  output logic oe_o,
  output logic ch_en_o,
  output logic dfp_o,
  output logic shift_tick_o,
  output logic sample_tick_o,
  output logic bus_mode_o
);
  localparam int FRAME_TICKS = TICKS_PER_BIT * FRAME_BITS;
  localparam int CNT_W       = $clog2(FRAME_TICKS);
  localparam int LIMIT       = MISS_FRAMES * FRAME_TICKS;

  logic [CNT_W-1:0] pos;
  logic             slave;
  tdm_strb_t        strb;

  tdm_pos_cnt #(
    .TICKS_PER_BIT(TICKS_PER_BIT), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
  ) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_ni(fp_ni), .pos_o(pos)
  );

  tdm_sync_mon #(.LIMIT(LIMIT)) i_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_ni(fp_ni), .slave_o(slave)
  );

  tdm_strb_dec #(
    .TICKS_PER_BIT(TICKS_PER_BIT), .FRAME_BITS(FRAME_BITS),
    .CH_BITS(CH_BITS), .DFP_BIT(DFP_BIT), .CNT_W(CNT_W)
  ) i_dec (
    .pos_i(pos), .lin_i(lin_i), .slave_i(slave), .strb_o(strb)
  );

  assign bclk_o        = strb.bclk;
  assign ch_en_o       = strb.ch_en;
  assign dfp_o         = strb.dfp;
  assign shift_tick_o  = strb.shift;
  assign sample_tick_o = strb.sample;
  assign oe_o          = !slave;
  assign bus_mode_o    = !slave;

  p_quiet_slave_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !(bclk_o || ch_en_o || dfp_o || shift_tick_o || sample_tick_o));
  p_tick_sep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_tick_o && sample_tick_o));
  p_shift_low_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_tick_o |-> !bclk_o);
  p_lin_no_dfp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_i |-> !dfp_o);
  p_pulse_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> (shift_tick_o && ch_en_o && oe_o));
endmodule

// File: tb/test_tdm_frame_timer.sv
module test_tdm_frame_timer;
  localparam int TPB   = 4;
  localparam int FTICK = TPB * 256;
  localparam int LIMIT = 2 * FTICK;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fp_ni = 1'b1;
  logic lin_i = 1'b0;
  logic bclk_o, oe_o, ch_en_o, dfp_o, shift_tick_o, sample_tick_o, bus_mode_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_pos = 0;
  int m_miss = 0;
  bit m_slave = 0;
  bit done = 0;

  tdm_frame_timer i_tdm_frame_timer (
    .clk_i(clk), .rst_ni(rst_ni), .fp_ni(fp_ni), .lin_i(lin_i),
    .bclk_o(bclk_o), .oe_o(oe_o), .ch_en_o(ch_en_o), .dfp_o(dfp_o),
    .shift_tick_o(shift_tick_o), .sample_tick_o(sample_tick_o),
    .bus_mode_o(bus_mode_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at pos %0d: actual %b expected %b", req, m_pos, act, exp);
    end
  endtask

  function automatic logic e_bclk(int p);   return (p % TPB) >= TPB / 2; endfunction
  function automatic logic e_shift(int p);  return (p % TPB) == 0; endfunction
  function automatic logic e_sample(int p); return (p % TPB) == 3; endfunction
  function automatic logic e_chen(int p, logic lin);
    return lin ? ((p / TPB) == 0) : ((p / TPB) < 8);
  endfunction
  function automatic logic e_dfp(int p, logic lin);
    return !lin && ((p / TPB) == 16);
  endfunction

  // compare every output against the model state
  task automatic check_all();
    if (m_slave) begin
      chk("R9", oe_o, 1'b0);
      chk("R9", bus_mode_o, 1'b0);
      chk("R9", bclk_o || ch_en_o || dfp_o || shift_tick_o || sample_tick_o, 1'b0);
    end else begin
      chk("R9", oe_o, 1'b1);
      chk("R9", bus_mode_o, 1'b1);
      chk("R3", bclk_o, e_bclk(m_pos));
      chk("R4", shift_tick_o, e_shift(m_pos));
      chk("R4", sample_tick_o, e_sample(m_pos));
      chk(lin_i ? "R6" : "R5", ch_en_o, e_chen(m_pos, lin_i));
      chk("R7", dfp_o, e_dfp(m_pos, lin_i));
    end
  endtask

  // called at a negedge: drive fp, take one edge, check at the next negedge
  task automatic step(input logic fp);
    bit was_slave;
    int prev;
    fp_ni = fp;
    @(posedge clk);
    was_slave = m_slave;
    prev = m_pos;
    if (!fp) begin
      m_pos = 0; m_miss = 0; m_slave = 0;
    end else begin
      m_pos = (m_pos + 1) % FTICK;
      if (m_miss == LIMIT - 1) m_slave = 1;
      else m_miss++;
    end
    @(negedge clk);
    fp_ni = 1'b1;
    check_all();
    if (!fp) begin
      chk(was_slave ? "R10" : "R2", shift_tick_o && ch_en_o && oe_o, 1'b1);
    end else if (prev == FTICK - 1 && !m_slave) begin
      chk("R8", shift_tick_o && ch_en_o && !bclk_o, 1'b1);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", oe_o, 1'b1);
    chk("R1", bus_mode_o, 1'b1);
    chk("R1", shift_tick_o, 1'b1);
    chk("R1", ch_en_o, 1'b1);
    chk("R1", bclk_o, 1'b0);
    chk("R1", sample_tick_o, 1'b0);
    chk("R1", dfp_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);

    // companded, pulses on frame boundaries
    step(1'b0); run(FTICK - 1);
    step(1'b0); run(FTICK - 1);
    // free-running wrap without pulse (R8)
    run(FTICK + 5);

    // linear mode frame
    lin_i = 1'b1;
    step(1'b0); run(FTICK + 10);
    lin_i = 1'b0;

    // random realignment, gaps below the slave limit
    for (int k = 0; k < 24; k++) begin
      lin_i = 1'(($urandom) & 1);
      run($urandom_range(1, 1600));
      step(1'b0);
    end
    // directed: back-to-back pulses
    step(1'b0); step(1'b0); run(3);
    lin_i = 1'b0;

    // slave entry exactly at the limit (R9)
    step(1'b0);
    run(LIMIT - 1);
    chk("R9", oe_o, 1'b1);
    step(1'b1);
    chk("R9", oe_o, 1'b0);
    run(300);
    // resume (R10) then check a full frame
    step(1'b0);
    chk("R10", bus_mode_o, 1'b1);
    run(FTICK);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule